// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Edge Interrupts

This block is a small bit-per-pin I/O port. Software sets, through a simple register interface, which pins are inputs and which are outputs, the level every output drives, whether an output is floated, whether an input's sense is inverted, and which inputs may raise an interrupt. The block drives a per-pin output-enable and output value toward the pad cells. It samples the pad inputs through a two-stage synchroniser.

Each input pin is seen through its inversion bit. A rising edge of that seen level, on a pin that is both an input and interrupt-enabled, sets a sticky pending bit. The single interrupt line is high while any pending bit belongs to a pin that is currently enabled and selected as an input. Reading the level register returns the live pin status and clears all pending bits, so an interrupt handler can take a snapshot and acknowledge in one access.

Top module: `mpio_port`

## Requirements
- R1: After reset, registers 0 to 5 all read 0x00, `pad_out` is 0x00, `pad_oe` is 0xFF (every pin an enabled output driving low) and `irq` is low.
- R2: Register 0 (direction) bit n = 1 makes pin n an input, with `pad_oe[n]` low. Bit n = 0 makes pin n an output.
- R3: Writing register 1 (level) sets `pad_out` on the clock edge of the write. For a pin that is an output, reading register 1 returns the bit last written.
- R4: For a pin that is an input, reading register 1 returns the pad level seen through the synchroniser, XORed with its bit in register 2 (invert). A pad change appears on the second rising clock edge after it.
- R5: Register 3 (float) bit n = 1 forces `pad_oe[n]` low even for an output pin. So `pad_oe = ~dir & ~float`.
- R6: Registers 0, 2, 3 and 4 (interrupt enable) read back what was written. Register 5 reads the pending bits and ignores writes. Addresses 6 and 7 read 0x00 and ignore writes.
- R7: A pending bit is set when the inverted, synchronised level of an input pin with its enable set goes from 0 to 1, on the third rising edge after the pad change. A bit that is set stays set. Writing register 2 alone never sets one.
- R8: Reading register 1 clears all pending bits. A new edge detected in the same cycle as the read is kept.
- R9: `irq` is the OR of pending bits whose pin is enabled and selected as an input. Clearing an enable bit masks `irq` but keeps the pending bit, which is visible in register 5.
- R10: Pins that are outputs, or whose enable bit is 0, never set a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, used for clear-on-read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, combinational from `bus_addr` |
| pad_in | input | W | Asynchronous pad input levels |
| pad_out | output | W | Pad output levels |
| pad_oe | output | W | Pad output enables, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the port with its default width of eight pins. At that width the full direction/float/invert/enable mix can be set up with distinct bit patterns: some pins are outputs, some are floated outputs and some are inputs, both inverted and plain. At eight pins the bench also reaches the cases where an output pin or a disabled pin toggles next to an enabled input. It reaches the race in which an edge lands in the same cycle as the clearing read, and it checks the two- and three-edge latencies exactly.

// File: rtl/mpio_port.sv
module mpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [2:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic         irq
);

  localparam logic [2:0] A_DIR = 3'd0;
  localparam logic [2:0] A_LVL = 3'd1;
  localparam logic [2:0] A_INV = 3'd2;
  localparam logic [2:0] A_FLT = 3'd3;
  localparam logic [2:0] A_IEN = 3'd4;
  localparam logic [2:0] A_PND = 3'd5;

  logic [W-1:0] dir_q, lvl_q, inv_q, flt_q, ien_q, pend_q;
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] seen, rise, armed;
  logic         ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
      inv_q <= '0;
      flt_q <= '0;
      ien_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DIR:   dir_q <= bus_wdata;
        A_LVL:   lvl_q <= bus_wdata;
        A_INV:   inv_q <= bus_wdata;
        A_FLT:   flt_q <= bus_wdata;
        A_IEN:   ien_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign seen  = sync_q ^ inv_q;
  assign rise  = seen & ~(prev_q ^ inv_q);
  assign armed = ien_q & dir_q;
  assign ack   = bus_rd && (bus_addr == A_LVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (ack) pend_q <= rise & armed;
    else          pend_q <= pend_q | (rise & armed);
  end

  always_comb begin
    case (bus_addr)
      A_DIR:   bus_rdata = dir_q;
      A_LVL:   bus_rdata = (dir_q & seen) | (~dir_q & lvl_q);
      A_INV:   bus_rdata = inv_q;
      A_FLT:   bus_rdata = flt_q;
      A_IEN:   bus_rdata = ien_q;
      A_PND:   bus_rdata = pend_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pad_out = lvl_q;
  assign pad_oe  = ~dir_q & ~flt_q;
  assign irq     = |(pend_q & armed);

endmodule

// File: rtl/mpio_port_chk.sv
module mpio_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic         bus_rd,
  input logic [2:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pend,
  input logic [W-1:0] rise
);

  AST_DIR_INPUT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0) |=> ((pad_oe & $past(bus_wdata)) == '0)); // R2

  AST_LEVEL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1) |=> (pad_out == $past(bus_wdata))); // R3

  AST_FLOAT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3) |=> ((pad_oe & $past(bus_wdata)) == '0)); // R5

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == 3'd1) |=> ((pend & $past(pend)) == $past(pend))); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd1 && rise == '0) |=> (pend == '0)); // R8

endmodule

bind mpio_port mpio_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .pend(pend_q), .rise(rise)
);

// File: tb/mpio_port_tb.sv
`timescale 1ns/1ps
module mpio_port_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, pad_in = '0;
  logic [W-1:0] bus_rdata, pad_out, pad_oe;
  logic         irq;
  int total = 0, bad = 0;
  logic [W-1:0] got;

  always #2 clk = ~clk;

  mpio_port #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // {addr, write data, expected readback}
  localparam logic [18:0] VEC [0:6] = '{
    {3'd0, 8'hA5, 8'hA5}, {3'd2, 8'h3C, 8'h3C}, {3'd3, 8'h0F, 8'h0F},
    {3'd4, 8'hF0, 8'hF0}, {3'd5, 8'hFF, 8'h00}, {3'd6, 8'h12, 8'h00},
    {3'd7, 8'h34, 8'h00}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic setp(input logic [W-1:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], got);
      chk("R1 reg reset", got, 8'h00);
    end
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 pad_oe", pad_oe, 8'hFF);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R6 register table
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], got);
      chk("R6 readback", got, VEC[i][7:0]);
    end
    for (int a = 0; a < 5; a++) wr(a[2:0], 8'h00);

    // R3 output level
    wr(3'd1, 8'h5A);
    chk("R3 pad_out", pad_out, 8'h5A);
    rd(3'd1, got);
    chk("R3 level readback", got, 8'h5A);

    // R2 direction
    wr(3'd0, 8'h0F);
    chk("R2 oe", pad_oe, 8'hF0);
    rd(3'd1, got);
    chk("R4 inputs low", got, 8'h50);

    // R5 float
    wr(3'd3, 8'h30);
    chk("R5 oe", pad_oe, 8'hC0);

    // R4 synchroniser latency and inversion
    setp(8'h06);
    rd(3'd1, got);
    chk("R4 one edge", got, 8'h50);
    rd(3'd1, got);
    chk("R4 two edges", got, 8'h56);
    wr(3'd2, 8'h01);
    rd(3'd1, got);
    chk("R4 inverted", got, 8'h57);

    // R7 inverted rising only
    wr(3'd4, 8'h0F);
    setp(8'h07);
    idle(4);
    chk("R7 raw rise inverted ignored", {7'd0, irq}, 8'h00);
    rd(3'd5, got);
    chk("R7 no pending", got, 8'h00);
    setp(8'h06);
    idle(2);
    chk("R7 not yet", {7'd0, irq}, 8'h00);
    idle(1);
    chk("R7 irq at third edge", {7'd0, irq}, 8'h01);
    rd(3'd5, got);
    chk("R7 pending bit0", got, 8'h01);
    setp(8'h07);
    idle(4);
    rd(3'd5, got);
    chk("R7 sticky", got, 8'h01);

    // R9 masking
    wr(3'd4, 8'h0E);
    chk("R9 masked irq", {7'd0, irq}, 8'h00);
    rd(3'd5, got);
    chk("R9 pending kept", got, 8'h01);
    wr(3'd4, 8'h0F);
    chk("R9 unmasked irq", {7'd0, irq}, 8'h01);

    // R8 clear on level read
    rd(3'd1, got);
    chk("R8 level value", got, 8'h56);
    chk("R8 irq cleared", {7'd0, irq}, 8'h00);
    rd(3'd5, got);
    chk("R8 pending cleared", got, 8'h00);

    // R10 output pin never pends
    wr(3'd4, 8'hFF);
    setp(8'h17);
    idle(4);
    rd(3'd5, got);
    chk("R10 output pin no pend", got, 8'h00);
    chk("R10 irq low", {7'd0, irq}, 8'h00);

    // R7 invert write makes no event
    wr(3'd2, 8'h00);
    idle(4);
    rd(3'd5, got);
    chk("R7 invert write no pend", got, 8'h00);
    rd(3'd1, got);
    chk("R4 plain level", got, 8'h57);

    // R8 edge in the clearing cycle survives
    setp(8'h13);
    idle(4);
    rd(3'd1, got);
    setp(8'h17);
    @(posedge clk);
    @(posedge clk);
    rd(3'd1, got);
    chk("R8 level at race", got, 8'h57);
    rd(3'd5, got);
    chk("R8 set wins", got, 8'h04);
    chk("R9 irq after race", {7'd0, irq}, 8'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule